// File: doc/BRIEF.md
# Video Memory Block Copy Engine

This engine moves a run of 16-bit words from one place in a 32K-word video memory to another place in the same memory. The host loads four 16-bit values beside it: a control word, a source pointer, a destination pointer and a length. A single-cycle start strobe then begins the transfer. For each word the engine spends one cycle reading the source through the shared memory port and one cycle writing that word to the destination. After each write, each pointer moves by one, up or down, in its own direction.

When the last word is written, the engine raises a done flag in a small status byte. If the control word asked for it, the engine also raises an interrupt line. The flag and the interrupt stay set until the host clears them, normally as a side effect of reading the status byte. While the transfer runs, the engine has sole use of the memory port and ignores any further start strobes.

Top module: `vram_copy_dma`

## Requirements
- R1: A start_i pulse sampled while idle captures all four inputs. busy_o rises at that clock edge. The first cycle of the transfer reads the address src_i[14:0].
- R2: Each word takes one read cycle (mem_re_o=1, mem_addr_o = current source) and then one write cycle (mem_we_o=1, mem_addr_o = current destination). mem_wdata_o equals the mem_rdata_i that the memory returns in the write cycle, which is the word read in the cycle before. Read and write are never asserted together.
- R3: Only len_i[14:0] is used. A value N copies N+1 words, so N=0 copies one word. busy_o stays high for exactly 2*(N+1) cycles.
- R4: ctrl_i bit 2 sets the source direction. With 0 the source address goes up by one after each word. With 1 it goes down by one.
- R5: ctrl_i bit 3 sets the destination direction in the same way.
- R6: Bit 15 of src_i and dst_i is ignored. Both addresses wrap modulo 32768: 0x7FFF steps up to 0x0000, and 0x0000 steps down to 0x7FFF.
- R7: At the clock edge where busy_o falls, status_o bit DONE_BIT (default 4, giving the value 0x10) is set. It stays set until status_clr_i is sampled high. All other status_o bits read 0.
- R8: irq_o rises together with the done flag only if ctrl_i bit 1 was 1 at start. It is cleared by status_clr_i.
- R9: A start_i pulse sampled while busy has no effect on addresses, data, word count or busy length.
- R10: If status_clr_i is high at the edge where a transfer completes, the done flag and the interrupt are still set at that edge.
- R11: After reset, busy_o, mem_re_o, mem_we_o, irq_o and status_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe from the host port |
| ctrl_i | input | 16 | Control word: bit 3 destination direction, bit 2 source direction, bit 1 interrupt enable |
| src_i | input | 16 | Source word address (low 15 bits used) |
| dst_i | input | 16 | Destination word address (low 15 bits used) |
| len_i | input | 16 | Word count minus one (low 15 bits used) |
| status_clr_i | input | 1 | Clears the done flag and the interrupt |
| mem_addr_o | output | 15 | Video memory word address |
| mem_re_o | output | 1 | Read strobe; data returns on the next cycle |
| mem_we_o | output | 1 | Write strobe |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, one cycle after mem_re_o |
| busy_o | output | 1 | Transfer in progress |
| status_o | output | 8 | Status byte holding the done flag |
| irq_o | output | 1 | Completion interrupt request |

## Verification
The host's status clear can land in the same cycle as the completion of a transfer. In that case the set and the clear of the done flag and the interrupt meet at one register edge. The bench provokes this by leaving the flags set from an earlier transfer and holding status_clr_i high for the whole of a new transfer. The flags are therefore cleared at its first edge, and the clear is still active at the final edge. The outcome is judged right when status_o reads 0x10, and irq_o follows the interrupt-enable bit, right after busy_o falls. A further lone clear must then remove both.

// File: rtl/vram_copy_pkg.sv
package vram_copy_pkg;
  typedef enum logic [1:0] {
    CP_IDLE  = 2'd0,
    CP_READ  = 2'd1,
    CP_WRITE = 2'd2
  } cp_state_e;
endpackage

// File: rtl/vc_addr_step.sv
module vc_addr_step #(
  parameter int AW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          down_i,
  input  logic          step_i,
  output logic [AW-1:0] ptr_o
);
  logic          down_q;
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      down_q <= 1'b0;
    end else if (load_i) begin
      ptr_q  <= base_i;
      down_q <= down_i;
    end else if (step_i) begin
      // natural AW-bit wrap
      ptr_q <= down_q ? ptr_q - 1'b1 : ptr_q + 1'b1;
    end
  end

  assign ptr_o = ptr_q;

  assert_ptr_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(ptr_q));
endmodule

// File: rtl/vc_seq.sv
module vc_seq
  import vram_copy_pkg::*;
#(
  parameter int CW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] len_i,
  output cp_state_e     state_o,
  output logic          load_o,
  output logic          step_o,
  output logic          done_o
);
  cp_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last   = (cnt_q == '0);
  assign load_o = start_i && (state_q == CP_IDLE);
  assign step_o = (state_q == CP_WRITE) && !last;
  assign done_o = (state_q == CP_WRITE) && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CP_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        CP_IDLE: if (start_i) begin
          state_q <= CP_READ;
          cnt_q   <= len_i;
        end
        CP_READ: state_q <= CP_WRITE;
        CP_WRITE: begin
          if (last) state_q <= CP_IDLE;
          else begin
            state_q <= CP_READ;
            cnt_q   <= cnt_q - 1'b1;
          end
        end
        default: state_q <= CP_IDLE;
      endcase
    end
  end

  assign state_o = state_q;

  assert_read_then_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CP_READ) |=> (state_q == CP_WRITE));
  assert_more_words_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CP_WRITE && cnt_q != '0) |=> (state_q == CP_READ));
  assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && state_q == CP_READ) |=> (state_q == CP_WRITE));
  assert_idle_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && state_q == CP_IDLE) |=> (state_q == CP_READ));
endmodule

// File: rtl/vc_status.sv
module vc_status #(
  parameter int SW       = 8,
  parameter int DONE_BIT = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic          irq_req_i,
  input  logic          clr_i,
  output logic [SW-1:0] status_o,
  output logic          irq_o
);
  logic done_q, irq_q;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (set_i) begin
      done_q <= 1'b1;
      irq_q  <= irq_req_i;
    end else if (clr_i) begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end
  end

  always_comb begin
    status_o           = '0;
    status_o[DONE_BIT] = done_q;
  end
  assign irq_o = irq_q;

  assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> status_o[DONE_BIT]);
  assert_irq_needs_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> status_o[DONE_BIT]);
  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> (status_o == '0 && !irq_o));
endmodule

// File: rtl/vram_copy_dma.sv
module vram_copy_dma
  import vram_copy_pkg::*;
#(
  parameter int AW          = 15,
  parameter int DW          = 16,
  parameter int RW          = 16,
  parameter int SW          = 8,
  parameter int DONE_BIT    = 4,
  parameter int DST_DIR_BIT = 3,
  parameter int SRC_DIR_BIT = 2,
  parameter int IRQ_EN_BIT  = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [RW-1:0] ctrl_i,
  input  logic [RW-1:0] src_i,
  input  logic [RW-1:0] dst_i,
  input  logic [RW-1:0] len_i,
  input  logic          status_clr_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_re_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic [SW-1:0] status_o,
  output logic          irq_o
);
  cp_state_e     state;
  logic          load, step, done;
  logic          irq_en_q;
  logic [AW-1:0] src_ptr, dst_ptr;

  vc_seq #(.CW(AW)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .len_i   (len_i[AW-1:0]),
    .state_o (state),
    .load_o  (load),
    .step_o  (step),
    .done_o  (done)
  );

  vc_addr_step #(.AW(AW)) u_src (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .base_i (src_i[AW-1:0]),
    .down_i (ctrl_i[SRC_DIR_BIT]),
    .step_i (step),
    .ptr_o  (src_ptr)
  );

  vc_addr_step #(.AW(AW)) u_dst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .base_i (dst_i[AW-1:0]),
    .down_i (ctrl_i[DST_DIR_BIT]),
    .step_i (step),
    .ptr_o  (dst_ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   irq_en_q <= 1'b0;
    else if (load) irq_en_q <= ctrl_i[IRQ_EN_BIT];
  end

  vc_status #(.SW(SW), .DONE_BIT(DONE_BIT)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (done),
    .irq_req_i (irq_en_q),
    .clr_i     (status_clr_i),
    .status_o  (status_o),
    .irq_o     (irq_o)
  );

  assign mem_re_o    = (state == CP_READ);
  assign mem_we_o    = (state == CP_WRITE);
  assign mem_addr_o  = mem_we_o ? dst_ptr : src_ptr;
  assign mem_wdata_o = mem_rdata_i;
  assign busy_o      = (state != CP_IDLE);

  assert_no_rw_overlap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));
  assert_done_on_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> status_o[DONE_BIT]);
  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_re_o && !mem_we_o));
  assert_irq_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $fell(busy_o));
endmodule

// File: tb/vram_copy_dma_tb.sv
module vram_copy_dma_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] ctrl = '0, src = '0, dst = '0, len = '0;
  logic        clr = 1'b0;
  logic [14:0] mem_addr;
  logic        mem_re, mem_we, busy, irq;
  logic [15:0] mem_wdata, mem_rdata = '0;
  logic [7:0]  status;

  int checks = 0, fails = 0;
  int words = 0, busy_cyc = 0, cyc = 0;
  logic [14:0] exp_src = '0, exp_dst = '0, last_rd = '0;
  logic        sdn = 1'b0, ddn = 1'b0, mon_on = 1'b0;

  always #4 clk = ~clk;

  vram_copy_dma u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ctrl_i(ctrl),
    .src_i(src), .dst_i(dst), .len_i(len), .status_clr_i(clr),
    .mem_addr_o(mem_addr), .mem_re_o(mem_re), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .status_o(status), .irq_o(irq)
  );

  function automatic logic [15:0] fdat(input logic [14:0] a);
    return {a[6:0], a[14:7], 1'b1} ^ 16'h5AC3;
  endfunction

  always @(posedge clk) if (mem_re) mem_rdata <= fdat(mem_addr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-word monitor (R1 R2 R4 R5 R6 R9)
  always @(negedge clk) begin
    if (mon_on) begin
      if (busy) busy_cyc++;
      if (mem_re) begin
        chk("R2/R4 read addr", 32'(mem_addr), 32'(exp_src));
        last_rd = exp_src;
        exp_src = sdn ? exp_src - 1'b1 : exp_src + 1'b1;
      end
      if (mem_we) begin
        chk("R2/R5 write addr", 32'(mem_addr), 32'(exp_dst));
        chk("R2 write data", 32'(mem_wdata), 32'(fdat(last_rd)));
        exp_dst = ddn ? exp_dst - 1'b1 : exp_dst + 1'b1;
        words++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run_copy(input logic [63:0] v, input bit glitch, input bit hold_clr);
    int n;
    n = 32'(v[14:0]) + 1;
    words = 0; busy_cyc = 0;
    exp_src = v[46:32]; exp_dst = v[30:16];
    sdn = v[50]; ddn = v[51];
    mon_on = 1'b1;
    @(negedge clk);
    ctrl = v[63:48]; src = v[47:32]; dst = v[31:16]; len = v[15:0];
    clr = hold_clr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 busy rise", 32'(busy), 1);
    if (glitch) begin
      start = 1'b1; src = 16'h1234; dst = 16'h2345; len = 16'h0007; ctrl = 16'h000C;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    clr = 1'b0;
    chk("R3 word count", 32'(words), 32'(n));
    chk("R3 busy cycles", 32'(busy_cyc), 32'(2 * n));
    chk("R7 done flag", 32'(status), 32'h10);
    chk(hold_clr ? "R10 irq set wins" : "R8 irq", 32'(irq), 32'(v[49]));
    mon_on = 1'b0;
  endtask

  task automatic clear_status();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk("R7 clear status", 32'(status), 0);
    chk("R8 clear irq", 32'(irq), 0);
  endtask

  // {ctrl, src, dst, len}
  localparam logic [63:0] VEC [7] = '{
    64'h0000_0010_0100_0003, // R4 R5 both up
    64'h0004_0020_0200_0004, // R4 source down
    64'h0008_0030_0300_0002, // R5 destination down
    64'h000E_0040_0400_0005, // R4 R5 both down, R8 irq
    64'h0002_FFFE_8001_8003, // R6 mask + source wrap up, R3 len bit15 ignored
    64'h0008_7FFE_0001_0003, // R6 destination wrap down
    64'h0002_0050_0500_0000  // R3 single word
  };

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 busy", 32'(busy), 0);
    chk("R11 rw", 32'({mem_re, mem_we}), 0);
    chk("R11 status", 32'(status), 0);
    chk("R11 irq", 32'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 7; i++) begin
      run_copy(VEC[i], 1'b0, 1'b0);
      clear_status();
    end
    // R9 start while busy
    run_copy(64'h0000_0600_0700_0004, 1'b1, 1'b0);
    // R10 clear collides with completion, flag left set beforehand
    run_copy(64'h0002_0800_0900_0002, 1'b0, 1'b1);
    clear_status();
    run_copy(64'h0000_0A00_0B00_0001, 1'b0, 1'b0);
    run_copy(64'h0002_0C00_0D00_0001, 1'b0, 1'b1);
    clear_status();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule